// File: doc/BRIEF.md
# Wide Multiply-Add with Split Result

This unit computes A*B+C at double width and hands back the full sum as two
single-width words, a low word and a high word. Because the high word is the
complete upper half of the exact sum, a caller can feed it into the C operand
of the next operation. That turns a series of these operations into a
multi-word scalar-by-vector multiply, with the high word serving as a
word-wide carry from one step to the next.

Two arithmetic modes are available. In unsigned mode every operand is a plain
unsigned number. In mixed mode A stays unsigned, while B and C are signed
two's complement values. This lets a signed multiplier scale an unsigned
multi-word magnitude.

The unit has no flags or status. A valid strobe travels with the operands. A
parameter chooses whether the result comes out combinationally or after one
register stage.

Top module: `wide_mac`

## Requirements
- R1: With mode_in = 0 (unsigned), A, B and C are unsigned. C is zero-extended to 2*W bits, neither shifted nor sign-extended. The result is the exact 2*W-bit value A*B+C.
- R2: lo_out carries bits W-1..0 of the 2*W-bit sum, and hi_out carries bits 2*W-1..W.
- R3: In unsigned mode no carry is lost. The largest case, all-ones*all-ones+all-ones, gives hi_out = all-ones and lo_out = 0.
- R4: With mode_in = 1 (mixed), A is zero-extended, and B and C are sign-extended to 2*W bits. The result is A*B+C modulo 2^(2*W).
- R5: In mixed mode with B negative, the product equals minus A times the magnitude of B. This includes B = the most negative value; for example, A = 2, B = 100..0, C = 0 gives hi_out = all-ones and lo_out = 0.
- R6: For the same A, B and C, lo_out is identical in both modes.
- R7: With STAGES = 0, the outputs follow the inputs in the same cycle, and valid_out equals valid_in.
- R8: With STAGES = 1, a result and its valid_out = 1 appear on the clock edge after the edge that sampled valid_in = 1.
- R9: With STAGES = 1, when valid_in is 0 at an edge, valid_out drops to 0 and lo_out and hi_out keep their previous values.
- R10: With STAGES = 1, a synchronous active-high reset clears valid_out, lo_out and hi_out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands on a_in, b_in, c_in, mode_in are valid |
| mode_in | input | 1 | 0 = unsigned, 1 = unsigned A by signed B, signed C |
| a_in | input | W (64) | Multiplicand, always unsigned |
| b_in | input | W (64) | Multiplier, signed in mixed mode |
| c_in | input | W (64) | Addend, signed in mixed mode |
| valid_out | output | 1 | Result words are valid |
| lo_out | output | W (64) | Bits W-1..0 of the sum |
| hi_out | output | W (64) | Bits 2*W-1..W of the sum |

## Verification
The bench builds two copies of the unit. The first is a 4-bit, one-stage copy. It sweeps every A, B and C in both modes, so every sign combination, the most negative value and the maximal unsigned sum are all reached, along with the latency, hold and reset behaviour of the register stage. The second is a 64-bit, zero-stage copy. It crosses a set of corner values (0, 1, all-ones, the most negative and the most positive) in both modes, then checks random operands. Each expected value comes from double-width arithmetic written in a different form from the datapath.

// File: rtl/wide_mac_pkg.sv
package wide_mac_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_MIXED    = 1'b1
    } mac_mode_e;

    localparam int unsigned MAX_STAGES = 1;

endpackage

// File: rtl/wide_mac_extend.sv
module wide_mac_extend
    import wide_mac_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  mac_mode_e       mode,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    c,
    output logic [2*W-1:0]  a_x,
    output logic [2*W-1:0]  b_x,
    output logic [2*W-1:0]  c_x
);

    logic b_sign;
    logic c_sign;

    // The sign bits only count in mixed mode; in unsigned mode they are forced to 0.
    always_comb begin
        b_sign = 1'b0;
        c_sign = 1'b0;
        case (mode)
            MODE_MIXED: begin
                b_sign = b[W-1];
                c_sign = c[W-1];
            end
            default: begin
                b_sign = 1'b0;
                c_sign = 1'b0;
            end
        endcase
    end

    // A is always zero-extended.
    assign a_x = {{W{1'b0}}, a};
    assign b_x = {{W{b_sign}}, b};
    assign c_x = {{W{c_sign}}, c};

endmodule

// File: rtl/wide_mac_core.sv
module wide_mac_core #(
    parameter int unsigned W = 64
) (
    input  logic [2*W-1:0]  a_x,
    input  logic [2*W-1:0]  b_x,
    input  logic [2*W-1:0]  c_x,
    output logic [2*W-1:0]  sum,
    output logic            carry
);

    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] prod;
    logic [DW:0]   full;

    // The product truncated to DW bits is the exact two's complement product
    // modulo 2^DW, so the same multiplier serves both modes.
    assign prod  = a_x * b_x;
    assign full  = {1'b0, prod} + {1'b0, c_x};
    assign sum   = full[DW-1:0];
    assign carry = full[DW];

endmodule

// File: rtl/wide_mac_stage.sv
module wide_mac_stage #(
    parameter int unsigned W      = 64,
    parameter int unsigned STAGES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_in,
    input  logic [2*W-1:0]  data_in,
    output logic            valid_out,
    output logic [2*W-1:0]  data_out
);

    generate
        if (STAGES == 0) begin : g_comb
            assign valid_out = valid_in;
            assign data_out  = data_in;
        end else begin : g_reg
            logic            vld_q;
            logic [2*W-1:0]  dat_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else begin
                    vld_q <= valid_in;
                    if (valid_in) begin
                        dat_q <= data_in;
                    end
                end
            end

            assign valid_out = vld_q;
            assign data_out  = dat_q;

            // R8: valid and data arrive one edge after being offered
            p_latency_r8: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (valid_out == $past(valid_in)));
            p_capture_r8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(valid_in)) |-> (data_out == $past(data_in)));
            // R9: an idle edge leaves the result words untouched
            p_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(valid_in)) |-> $stable(data_out));
        end
    endgenerate

endmodule

// File: rtl/wide_mac.sv
module wide_mac
    import wide_mac_pkg::*;
#(
    parameter int unsigned W      = 64,
    parameter int unsigned STAGES = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_in,
    input  logic          mode_in,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic [W-1:0]  c_in,
    output logic          valid_out,
    output logic [W-1:0]  lo_out,
    output logic [W-1:0]  hi_out
);

    localparam int unsigned DW = 2 * W;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } split_t;

    mac_mode_e      mode_s;
    logic [DW-1:0]  a_x;
    logic [DW-1:0]  b_x;
    logic [DW-1:0]  c_x;
    logic [DW-1:0]  sum_w;
    logic           carry_w;
    split_t         res_d;
    split_t         res_q;

    assign mode_s = mac_mode_e'(mode_in);

    wide_mac_extend #(.W(W)) u_extend (
        .mode (mode_s),
        .a    (a_in),
        .b    (b_in),
        .c    (c_in),
        .a_x  (a_x),
        .b_x  (b_x),
        .c_x  (c_x)
    );

    wide_mac_core #(.W(W)) u_core (
        .a_x   (a_x),
        .b_x   (b_x),
        .c_x   (c_x),
        .sum   (sum_w),
        .carry (carry_w)
    );

    assign res_d = split_t'(sum_w);

    wide_mac_stage #(.W(W), .STAGES((STAGES > MAX_STAGES) ? MAX_STAGES : STAGES)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .data_in   (res_d),
        .valid_out (valid_out),
        .data_out  (res_q)
    );

    assign lo_out = res_q.lo;
    assign hi_out = res_q.hi;

    // Single-width reference for the low word, which ignores extension entirely.
    logic [W-1:0] low_ref;
    assign low_ref = a_in * b_in + c_in;

    // R6: low word equals the single-width result in either mode
    p_low_mod_r6: assert property (@(posedge clk) disable iff (rst)
        sum_w[W-1:0] == low_ref);
    // R3: unsigned addition never carries out of the double-width sum
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_s == MODE_UNSIGNED) |-> !carry_w);
    // R5: nonzero A times negative B with no addend yields a negative sum
    p_neg_sign_r5: assert property (@(posedge clk) disable iff (rst)
        ((mode_s == MODE_MIXED) && b_in[W-1] && (a_in != '0) && (c_in == '0))
            |-> sum_w[DW-1]);

endmodule

// File: tb/wide_mac_tb.sv
`timescale 1ns/1ps
module wide_mac_tb;

    localparam int NW = 4;
    localparam int WW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // narrow, one-stage instance
    logic          n_vin = 1'b0, n_mode = 1'b0;
    logic [NW-1:0] n_a = '0, n_b = '0, n_c = '0;
    logic          n_vout;
    logic [NW-1:0] n_lo, n_hi;

    wide_mac #(.W(NW), .STAGES(1)) u_dut (
        .clk(clk), .rst(rst), .valid_in(n_vin), .mode_in(n_mode),
        .a_in(n_a), .b_in(n_b), .c_in(n_c),
        .valid_out(n_vout), .lo_out(n_lo), .hi_out(n_hi)
    );

    // wide, combinational instance
    logic          w_vin = 1'b0, w_mode = 1'b0;
    logic [WW-1:0] w_a = '0, w_b = '0, w_c = '0;
    logic          w_vout;
    logic [WW-1:0] w_lo, w_hi;

    wide_mac #(.W(WW), .STAGES(0)) u_dut_wide (
        .clk(clk), .rst(rst), .valid_in(w_vin), .mode_in(w_mode),
        .a_in(w_a), .b_in(w_b), .c_in(w_c),
        .valid_out(w_vout), .lo_out(w_lo), .hi_out(w_hi)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] wide_ref(input logic m, input logic [63:0] a,
                                              input logic [63:0] b, input logic [63:0] c);
        logic [127:0] ax, mag, p, cx;
        ax = {64'd0, a};
        if (m && b[63]) begin
            mag = 128'd0 - {{64{1'b1}}, b};
            p   = 128'd0 - (ax * mag);
        end else begin
            p = ax * {64'd0, b};
        end
        cx = (m && c[63]) ? {{64{1'b1}}, c} : {64'd0, c};
        return p + cx;
    endfunction

    function automatic logic [63:0] corner(input int i);
        case (i)
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h7fff_ffff_ffff_ffff;
            default: return 64'h0123_4567_89ab_cdef;
        endcase
    endfunction

    task automatic wide_try(input logic m, input logic [63:0] a,
                            input logic [63:0] b, input logic [63:0] c, input string tag);
        logic [127:0] e;
        @(negedge clk);
        w_mode = m; w_a = a; w_b = b; w_c = c;
        #1;
        e = wide_ref(m, a, b, c);
        check({w_hi, w_lo} == e, tag, {w_hi, w_lo}, e);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check(n_vout == 1'b0 && n_lo == '0 && n_hi == '0, "R10 reset",
              {n_vout, n_hi, n_lo}, 128'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(n_vout == 1'b0, "R10 idle after reset", n_vout, 0);

        // Exhaustive narrow sweep: R1 R2 R4 R5 R8
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int c = 0; c < 16; c++) begin
                        int sb, sc, s;
                        logic [7:0] e;
                        @(negedge clk);
                        n_vin = 1'b1; n_mode = m[0];
                        n_a = a[3:0]; n_b = b[3:0]; n_c = c[3:0];
                        @(posedge clk); #1;
                        sb = (m == 1 && b >= 8) ? b - 16 : b;
                        sc = (m == 1 && c >= 8) ? c - 16 : c;
                        s  = a * sb + sc;
                        e  = 8'(s & 255);
                        check(n_vout && {n_hi, n_lo} == e,
                              (m == 0) ? "R1 R2 R8 unsigned sweep" : "R4 R5 R8 mixed sweep",
                              {n_vout, n_hi, n_lo}, {1'b1, e});
                    end
                end
            end
        end

        // R9: idle edge holds result and drops valid (3*5+1 = 16 -> hi 1, lo 0)
        @(negedge clk);
        n_vin = 1'b1; n_mode = 1'b0; n_a = 4'd3; n_b = 4'd5; n_c = 4'd1;
        @(posedge clk); #1;
        check(n_vout && n_hi == 4'd1 && n_lo == 4'd0, "R8 capture", {n_vout, n_hi, n_lo}, 9'h110);
        @(negedge clk);
        n_vin = 1'b0; n_a = 4'hf; n_b = 4'hf; n_c = 4'hf;
        @(posedge clk); #1;
        check(!n_vout && n_hi == 4'd1 && n_lo == 4'd0, "R9 hold", {n_vout, n_hi, n_lo}, 9'h010);

        // R7: combinational valid
        @(negedge clk);
        w_vin = 1'b1; #1;
        check(w_vout == 1'b1, "R7 valid high", w_vout, 1);
        w_vin = 1'b0; #1;
        check(w_vout == 1'b0, "R7 valid low", w_vout, 0);

        // R3 and R5 explicit corners
        wide_try(1'b0, '1, '1, '1, "R3 all-ones");
        check(w_hi == '1 && w_lo == '0, "R3 all-ones words", {w_hi, w_lo}, {64'hffff_ffff_ffff_ffff, 64'd0});
        wide_try(1'b1, 64'd2, 64'h8000_0000_0000_0000, 64'd0, "R5 most negative");
        check(w_hi == '1 && w_lo == '0, "R5 most negative words", {w_hi, w_lo}, {64'hffff_ffff_ffff_ffff, 64'd0});

        // Corner cross in both modes, with R6 low word comparison
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [63:0] lo_u;
                    wide_try(1'b0, corner(i), corner(j), corner(k), "R1 R2 wide corner");
                    lo_u = w_lo;
                    wide_try(1'b1, corner(i), corner(j), corner(k), "R4 R5 wide corner");
                    check(w_lo == lo_u, "R6 low word mode-independent", w_lo, lo_u);
                end
            end
        end

        // Random wide operands
        for (int r = 0; r < 200; r++) begin
            logic [63:0] ra, rb, rc;
            ra = {$urandom, $urandom}; rb = {$urandom, $urandom}; rc = {$urandom, $urandom};
            wide_try(r[0], ra, rb, rc, r[0] ? "R4 wide random" : "R1 wide random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule